// File: doc/BRIEF.md
# PWM Time Base

This block is the counting core of a pulse-width modulator. A 12-bit counter advances on a clock-enable tick after a selectable prescaler. It runs in one of three modes: free-running wrap, single-shot, or continuous up/down. Software writes a buffered period, the counter itself, a control word and a trigger word through simple write strobes. The active period is refreshed from the buffer only at safe points.

The block drives the counter value, the active period, a running flag and a direction flag. It also drives a one-cycle period-boundary strobe and an inhibit flag that keeps downstream duty logic quiet during the first rising half of an up/down run. Its last output is a postscaled event trigger that fires when the counter reaches a compare value while moving in a chosen direction. Duty comparators, dead time and output drivers sit outside this block.

Top module: `pwm_timebase`

## Requirements
- R1: After reset, cnt, per_now, run, down, wrap, inhibit and trig are all zero.
- R2: Mode 00 (free-running) advances the counter by one per step while it is below per_now. A step taken at or above per_now loads 0 and pulses wrap for one cycle. Counting continues while run stays 1.
- R3: Mode 01 (single-shot) counts as in R2. The step that returns the counter to 0 also pulses wrap and clears run, and the counter then holds.
- R4: Modes 10 and 11 (up/down) count up until the counter reaches per_now, and the next step counts down with down=1. The step taken at 0 while counting down sets down=0, loads 1 and pulses wrap, so one period spans 2×per_now steps. Enabling from a stopped state starts counting up.
- R5: ctl_psc sets the number of qualified ticks per step: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64. The first step comes that many ticks after the enabling write.
- R6: A cycle with cnt_we, ctl_we or trg_we clears the prescaler and takes no step.
- R7: A control write leaves the counter value unchanged. cnt_we loads cnt_wd into the counter.
- R8: Enabling in up/down mode raises inhibit. Inhibit falls at the first turn from up to down, and it is 0 in every other mode.
- R9: The buffered period is copied into per_now while the block is stopped, or on a step that pulses wrap. The copy happens only when the update-disable bit is 0. With that bit at 1, per_now holds.
- R10: A match is a step whose new counter value equals trg_cmp while down equals trg_down. trig pulses for one cycle, one cycle after the counter takes that value, on every (trg_post+1)-th match. The match count is cleared while run is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable feeding the prescaler |
| per_we | input | 1 | Write strobe for the period buffer |
| per_wd | input | 12 | Period buffer write data |
| cnt_we | input | 1 | Write strobe for the counter |
| cnt_wd | input | 12 | Counter write data |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_mode | input | 2 | 00 free, 01 single-shot, 1x up/down |
| ctl_psc | input | 2 | Prescale select |
| ctl_en | input | 1 | Enable written with the control word |
| ctl_udis | input | 1 | Update-disable for the period buffer |
| trg_we | input | 1 | Write strobe for the trigger word |
| trg_cmp | input | 12 | Trigger compare value |
| trg_post | input | 4 | Postscale select, N = value+1 |
| trg_down | input | 1 | 1 = match while counting down, 0 = while counting up |
| cnt | output | 12 | Counter value |
| per_now | output | 12 | Active period |
| run | output | 1 | Enable state, cleared by hardware in single-shot |
| down | output | 1 | Direction flag |
| wrap | output | 1 | One-cycle period boundary strobe |
| inhibit | output | 1 | First-half output inhibit |
| trig | output | 1 | Postscaled event trigger pulse |

## Verification
Two events can land on the same edge: a register write and a prescaler step that was due. The bench provokes this in two ways. With the 1:4 prescale running, it writes the trigger word and then the counter partway through a prescale window. In free mode it rewrites the control word to release the update-disable bit while steps arrive every tick. In each case the scoreboard expects the counter to hold on the write edge and the next step to come a full prescale window later. A second collision is a boundary step together with a new buffered period. The bench judges it by the wrap point of the following period.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W  = 12,
  parameter int PW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         per_we,
  input  logic [W-1:0] per_wd,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wd,
  input  logic         ctl_we,
  input  logic [1:0]   ctl_mode,
  input  logic [1:0]   ctl_psc,
  input  logic         ctl_en,
  input  logic         ctl_udis,
  input  logic         trg_we,
  input  logic [W-1:0] trg_cmp,
  input  logic [PW-1:0] trg_post,
  input  logic         trg_down,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per_now,
  output logic         run,
  output logic         down,
  output logic         wrap,
  output logic         inhibit,
  output logic         trig
);
  localparam logic [1:0] M_FREE = 2'b00;
  localparam logic [1:0] M_ONE  = 2'b01;

  logic [1:0]    mode, psc;
  logic          udis, tdown, stepd;
  logic [W-1:0]  per_buf, cmp;
  logic [PW-1:0] post, pcnt;
  logic [5:0]    pre, lim;
  logic          updn, any_wr, step, bnd, match;

  assign updn   = mode[1];
  assign lim    = {{2{psc == 2'd3}}, {2{psc[1]}}, {2{psc != 2'd0}}};
  assign any_wr = cnt_we | ctl_we | trg_we;
  assign step   = tick & run & (pre == lim) & ~any_wr;
  assign bnd    = step & (updn ? (down & (cnt == '0)) : (cnt >= per_now));
  assign match  = stepd & (cnt == cmp) & (down == tdown);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             pre <= '0;
    else if (any_wr)        pre <= '0;
    else if (tick && run)   pre <= (pre == lim) ? '0 : pre + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= M_FREE; psc <= '0; udis <= 1'b0;
      cmp <= '0; post <= '0; tdown <= 1'b0; per_buf <= '0;
    end else begin
      if (ctl_we) begin mode <= ctl_mode; psc <= ctl_psc; udis <= ctl_udis; end
      if (trg_we) begin cmp <= trg_cmp; post <= trg_post; tdown <= trg_down; end
      if (per_we) per_buf <= per_wd;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                         per_now <= '0;
    else if (!udis && (!run || bnd))    per_now <= per_buf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; run <= 1'b0; down <= 1'b0; wrap <= 1'b0; inhibit <= 1'b0;
    end else begin
      wrap <= bnd;
      if (cnt_we) cnt <= cnt_wd;
      if (ctl_we) begin
        run <= ctl_en;
        if (!ctl_en || !ctl_mode[1]) inhibit <= 1'b0;
        else if (!run)                inhibit <= 1'b1;
        if (!ctl_mode[1] || (ctl_en && !run)) down <= 1'b0;
      end else if (step) begin
        if (!updn) begin
          if (cnt >= per_now) begin
            cnt <= '0;
            if (mode == M_ONE) run <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end else if (!down) begin
          if (cnt >= per_now) begin
            down <= 1'b1; inhibit <= 1'b0;
            cnt <= (cnt == '0) ? '0 : cnt - 1'b1;
          end else cnt <= cnt + 1'b1;
        end else if (cnt == '0) begin
          down <= 1'b0;
          cnt  <= (per_now == '0) ? '0 : W'(1);
        end else cnt <= cnt - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stepd <= 1'b0; pcnt <= '0; trig <= 1'b0;
    end else begin
      stepd <= step;
      trig  <= run & match & (pcnt == post);
      if (!run)       pcnt <= '0;
      else if (match) pcnt <= (pcnt == post) ? '0 : pcnt + 1'b1;
    end

  // R3
  hw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) && !$past(ctl_we) |-> $past(mode) == M_ONE);
  // R4
  down_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    down |-> updn);
  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> run && updn && !down);
  // R2
  free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && $past(mode) == M_FREE && !$past(any_wr) && cnt != $past(cnt)
    |-> cnt == W'($past(cnt) + 1'b1) || cnt == '0);
  // R5
  presc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(any_wr) && cnt != $past(cnt) |-> $past(tick) && $past(pre) == $past(lim));
  // R9
  hold_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(udis) |-> $stable(per_now));
  // R10
  trig_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(run));
endmodule

// File: tb/test_pwm_timebase.sv
module test_pwm_timebase;
  logic clk = 0, rst_n = 0, tick = 1;
  logic per_we = 0, cnt_we = 0, ctl_we = 0, trg_we = 0;
  logic [11:0] per_wd = 0, cnt_wd = 0, trg_cmp = 0;
  logic [1:0] ctl_mode = 0, ctl_psc = 0;
  logic ctl_en = 0, ctl_udis = 0, trg_down = 0;
  logic [3:0] trg_post = 0;
  logic [11:0] cnt, per_now;
  logic run, down, wrap, inhibit, trig;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_timebase i_pwm_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .per_we(per_we), .per_wd(per_wd), .cnt_we(cnt_we), .cnt_wd(cnt_wd),
    .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_psc(ctl_psc), .ctl_en(ctl_en),
    .ctl_udis(ctl_udis), .trg_we(trg_we), .trg_cmp(trg_cmp), .trg_post(trg_post),
    .trg_down(trg_down), .cnt(cnt), .per_now(per_now), .run(run), .down(down),
    .wrap(wrap), .inhibit(inhibit), .trig(trig));

  typedef struct {
    logic [11:0] c;
    logic [4:0]  f;
    logic [4:0]  fm;
    string       r;
  } item_t;
  item_t q[$];

  // flag vector {run,down,wrap,inhibit,trig}
  localparam logic [4:0] FR = 5'b10000, FD = 5'b01000, FW = 5'b00100, FI = 5'b00010, FT = 5'b00001;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      automatic item_t it = q.pop_front();
      automatic logic [4:0] fl = {run, down, wrap, inhibit, trig};
      chk(cnt == it.c, it.r, "cnt", cnt, it.c);
      if (it.fm != 0) chk((fl & it.fm) == (it.f & it.fm), it.r, "flags", fl & it.fm, it.f & it.fm);
    end
  end

  task automatic clr();
    per_we = 0; cnt_we = 0; ctl_we = 0; trg_we = 0;
  endtask
  task automatic go(input logic [11:0] c, input logic [4:0] f, input logic [4:0] fm, input string r);
    @(posedge clk);
    q.push_back('{c: c, f: f, fm: fm, r: r});
    #1 clr();
  endtask
  task automatic nop();
    @(posedge clk); #1 clr();
  endtask
  task automatic ctl(input logic [1:0] m, input logic [1:0] p, input logic e, input logic u);
    ctl_we = 1; ctl_mode = m; ctl_psc = p; ctl_en = e; ctl_udis = u;
  endtask
  task automatic stop_clear();
    ctl(2'b00, 2'b00, 0, 0); cnt_we = 1; cnt_wd = 0; nop();
  endtask
  task automatic setper(input logic [11:0] p);
    per_we = 1; per_wd = p; nop(); nop();
  endtask
  task automatic trgw(input logic [11:0] c, input logic [3:0] p, input logic d);
    trg_we = 1; trg_cmp = c; trg_post = p; trg_down = d;
  endtask
  function automatic logic [11:0] ud_cnt(input int k);
    int ph = (k - 1) % 6 + 1;
    return (ph <= 3) ? 12'(ph) : 12'(6 - ph);
  endfunction

  initial begin
    repeat (8000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(cnt == 0 && per_now == 0, "R1", "cnt/per", cnt, 0);
    chk({run, down, wrap, inhibit, trig} == 0, "R1", "flags", {run, down, wrap, inhibit, trig}, 0);
    rst_n = 1;
    nop();

    // R2 free-running, period 3
    setper(3);
    chk(per_now == 3, "R9", "per_now while stopped", per_now, 3);
    ctl(2'b00, 2'b00, 1, 0); go(0, FR, FR | FW, "R2");
    for (int k = 1; k <= 9; k++) go(12'(k % 4), FR | ((k % 4 == 0) ? FW : 5'b0), FR | FW, "R2");
    // R7 control write keeps counter
    ctl(2'b00, 2'b00, 0, 0); go(1, 0, FR, "R7");
    go(1, 0, FR, "R7");
    cnt_we = 1; cnt_wd = 12'd77; go(77, 0, 0, "R7");

    // R5 prescale ratios
    stop_clear();
    setper(12'hFFF);
    for (int p = 0; p < 4; p++) begin
      automatic int r = 1 << (2 * p);
      stop_clear();
      ctl(2'b00, 2'(p), 1, 0); go(0, FR, FR, "R5");
      for (int k = 1; k <= 3 * r; k++) go(12'(k / r), FR, FR, "R5");
    end

    // R6 writes clear the prescaler and block the step
    stop_clear();
    ctl(2'b00, 2'b01, 1, 0); go(0, FR, FR, "R6");
    go(0, 0, 0, "R6"); go(0, 0, 0, "R6");
    trgw(12'd4000, 0, 0); go(0, 0, 0, "R6");
    go(0, 0, 0, "R6"); go(0, 0, 0, "R6"); go(0, 0, 0, "R6");
    go(1, 0, 0, "R6");
    go(1, 0, 0, "R6"); go(1, 0, 0, "R6");
    cnt_we = 1; cnt_wd = 12'd100; go(100, 0, 0, "R7");
    go(100, 0, 0, "R6"); go(100, 0, 0, "R6"); go(100, 0, 0, "R6");
    go(101, 0, 0, "R6");

    // R3 single-shot
    stop_clear();
    setper(2);
    ctl(2'b01, 2'b00, 1, 0); go(0, FR, FR | FW, "R3");
    go(1, FR, FR | FW, "R3"); go(2, FR, FR | FW, "R3");
    go(0, FW, FR | FW, "R3");
    go(0, 0, FR | FW, "R3"); go(0, 0, FR | FW, "R3");

    // R4 / R8 up/down
    stop_clear();
    setper(3);
    ctl(2'b10, 2'b00, 1, 0); go(0, FR | FI, FR | FD | FW | FI, "R8");
    for (int k = 1; k <= 14; k++) begin
      automatic int ph = (k - 1) % 6 + 1;
      automatic logic [4:0] f = FR | ((ph >= 4) ? FD : 5'b0) | ((ph == 1 && k > 1) ? FW : 5'b0)
                                | ((k <= 3) ? FI : 5'b0);
      go(ud_cnt(k), f, FR | FD | FW | FI, (k <= 4) ? "R8" : "R4");
    end
    ctl(2'b00, 2'b00, 1, 0); go(2, FR, FD | FI, "R8");

    // R9 update disable, then boundary-only copy
    stop_clear();
    setper(3);
    ctl(2'b00, 2'b00, 1, 1); go(0, FR, FR, "R9");
    per_we = 1; per_wd = 5; go(1, FR, FR, "R9");
    for (int k = 2; k <= 9; k++) go(12'(k % 4), FR | ((k % 4 == 0) ? FW : 5'b0), FR | FW, "R9");
    chk(per_now == 3, "R9", "per_now held", per_now, 3);
    ctl(2'b00, 2'b00, 1, 0); go(1, FR, FR, "R6");
    go(2, 0, FW, "R9"); go(3, 0, FW, "R9"); go(0, FW, FW, "R9");
    chk(per_now == 5, "R9", "per_now copied", per_now, 5);
    for (int k = 1; k <= 5; k++) go(12'(k), 0, FW, "R9");
    go(0, FW, FW, "R9");
    per_we = 1; per_wd = 2; go(1, 0, FW, "R9");
    chk(per_now == 5, "R9", "per_now before boundary", per_now, 5);
    go(2, 0, FW, "R9"); go(3, 0, FW, "R9"); go(4, 0, FW, "R9"); go(5, 0, FW, "R9");
    go(0, FW, FW, "R9"); go(1, 0, FW, "R9"); go(2, 0, FW, "R9"); go(0, FW, FW, "R9");

    // R10 trigger, free mode, 1:2 postscale, counting up
    stop_clear();
    setper(3);
    trgw(2, 1, 0); nop();
    ctl(2'b00, 2'b00, 1, 0); go(0, 0, FT, "R10");
    for (int k = 1; k <= 16; k++) go(12'(k % 4), (k == 7 || k == 15) ? FT : 5'b0, FT, "R10");
    // R10 postscaler cleared while stopped
    stop_clear();
    ctl(2'b00, 2'b00, 1, 0); go(0, 0, FT, "R10");
    for (int k = 1; k <= 4; k++) go(12'(k % 4), 0, FT, "R10");
    ctl(2'b00, 2'b00, 0, 0); go(0, 0, FT, "R10");
    ctl(2'b00, 2'b00, 1, 0); go(0, 0, FT, "R10");
    for (int k = 1; k <= 8; k++) go(12'(k % 4), (k == 7) ? FT : 5'b0, FT, "R10");
    // R10 trigger in up/down, counting down, 1:1
    stop_clear();
    trgw(2, 0, 1); nop();
    ctl(2'b10, 2'b00, 1, 0); go(0, 0, FT, "R10");
    for (int k = 1; k <= 12; k++) go(ud_cnt(k), (k == 5 || k == 11) ? FT : 5'b0, FT, "R10");

    nop(); nop();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule